// File: doc/BRIEF.md
# Video Capture Run-Mode Sequencer

This block decides, cycle by cycle, whether incoming video is being captured. Software-side logic hands it a 3-bit run-mode code with a one-cycle write strobe. Two codes act at once: one starts capture and one stops it. The other six codes start or stop capture at the next line, field or frame boundary. A pending request waits until its boundary arrives. A new write replaces any request that has not yet been served.

Boundaries come from three timing inputs:
- A one-cycle end-of-line pulse marks a line boundary.
- A rising edge of the vertical-blanking level marks a field boundary.
- A field-parity level tells whether the field that just ended was the odd one.

A progressive-mode pin sets the framing. In progressive mode every field boundary is also a frame boundary. In interlaced mode only the end of the odd field is a frame boundary.

The outputs are a capture-active level and one-cycle start-of-frame and end-of-frame pulses. No pixel data passes through the block. There is therefore no valid/ready interface and no back-pressure; every pin is a plain control or status pin.

Top module: `vcap_run_seq`

## Requirements
- R1: After reset, `capture_o`, `sof_o` and `eof_o` are 0 and no request is pending.
- R2: A write of code 3'b111 makes `capture_o` 1 on the next cycle. A write of 3'b000 makes it 0 on the next cycle. Both cancel any pending request.
- R3: Code 3'b100 starts capture, and code 3'b001 stops it, on the cycle after the next `line_end_i` pulse. Field and frame boundaries do not serve these requests.
- R4: Code 3'b101 starts capture, and code 3'b010 stops it, on the cycle after the next rising edge of `vblank_i`. Line pulses do not serve these requests.
- R5: In interlaced mode (`progressive_i` = 0), a frame boundary is a rising edge of `vblank_i` while `field_odd_i` = 1. Code 3'b110 starts capture, and code 3'b011 stops it, on the cycle after such a boundary. A rising edge of `vblank_i` while `field_odd_i` = 0 does not serve these requests.
- R6: In progressive mode (`progressive_i` = 1), every rising edge of `vblank_i` is a frame boundary, whatever the value of `field_odd_i`.
- R7: A write of a new code discards any request that has not yet been served. The boundary of the discarded request then has no effect.
- R8: `sof_o` pulses for one cycle after a frame boundary at which capture is active or begins. `eof_o` pulses for one cycle after a frame boundary at which capture was already active. At a frame boundary that finds capture inactive and not starting, neither output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_i | input | 1 | One-cycle strobe that writes `cmd_i` |
| cmd_i | input | 3 | Run-mode code: bit 2 = start, low bits = boundary |
| progressive_i | input | 1 | 1 = progressive framing, 0 = interlaced |
| line_end_i | input | 1 | One-cycle end-of-line pulse |
| vblank_i | input | 1 | Vertical-blanking level; rising edge = field boundary |
| field_odd_i | input | 1 | 1 while the current field is the odd one |
| capture_o | output | 1 | Capture active |
| sof_o | output | 1 | Start-of-frame pulse |
| eof_o | output | 1 | End-of-frame pulse |

## Verification
A wrong pending-request state, such as the wrong boundary kind or a request that was not cleared, shows as `capture_o` changing at the wrong boundary. It can also show as `capture_o` not changing, or as a request taking effect after a later write should have replaced it. Each of these is visible one cycle after the boundary in question. A wrong edge-detect or parity decision shows on the same cycle, as a frame pulse on an even-field blanking edge or a missing pulse on an odd one. Each scenario therefore drives one boundary of each kind and checks the outputs on the cycle after that boundary.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [1:0] {
    BND_NOW   = 2'd0,
    BND_LINE  = 2'd1,
    BND_FIELD = 2'd2,
    BND_FRAME = 2'd3
  } bnd_e;

  typedef struct packed {
    logic start;
    bnd_e bnd;
  } req_t;

  // Map a 3-bit code to a request: bit 2 selects start.
  // Stop codes use bits [1:0] directly (00 = now).
  // Start codes 100/101/110 mean line/field/frame, and 111 means now.
  function automatic req_t decode_cmd(input logic [CMD_W-1:0] c);
    req_t r;
    r.start = c[2];
    if (!c[2]) begin
      r.bnd = bnd_e'(c[1:0]);
    end else begin
      unique case (c[1:0])
        2'b00:   r.bnd = BND_LINE;
        2'b01:   r.bnd = BND_FIELD;
        2'b10:   r.bnd = BND_FRAME;
        default: r.bnd = BND_NOW;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/vcap_timing.sv
module vcap_timing (
  input  logic clk,
  input  logic rst_n,
  input  logic progressive_i,
  input  logic line_end_i,
  input  logic vblank_i,
  input  logic field_odd_i,
  output logic line_evt_o,
  output logic field_evt_o,
  output logic frame_evt_o
);
  logic vblank_q;

  // Reset to 1 so that a blanking level already high at reset is not taken as an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) vblank_q <= 1'b1;
    else        vblank_q <= vblank_i;
  end

  always_comb begin
    line_evt_o  = line_end_i;
    field_evt_o = vblank_i & ~vblank_q;
    frame_evt_o = field_evt_o & (progressive_i | field_odd_i);
  end
endmodule

// File: rtl/vcap_request.sv
module vcap_request
  import vcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             line_evt_i,
  input  logic             field_evt_i,
  input  logic             frame_evt_i,
  output logic             act_o,
  output logic             act_start_o
);
  req_t pend_q;
  logic pend_vld_q;
  req_t req_new;
  logic hit;

  always_comb begin
    req_new = decode_cmd(cmd_i);
    unique case (pend_q.bnd)
      BND_LINE:  hit = line_evt_i;
      BND_FIELD: hit = field_evt_i;
      BND_FRAME: hit = frame_evt_i;
      default:   hit = 1'b0;
    endcase
    hit = hit & pend_vld_q & ~cmd_wr_i;
    if (cmd_wr_i && req_new.bnd == BND_NOW) begin
      act_o       = 1'b1;
      act_start_o = req_new.start;
    end else begin
      act_o       = hit;
      act_start_o = pend_q.start;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld_q <= 1'b0;
      pend_q     <= '{start: 1'b0, bnd: BND_NOW};
    end else if (cmd_wr_i) begin
      pend_vld_q <= (req_new.bnd != BND_NOW);
      pend_q     <= req_new;
    end else if (hit) begin
      pend_vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vcap_state.sv
module vcap_state (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic act_start_i,
  input  logic frame_evt_i,
  output logic capture_o,
  output logic sof_o,
  output logic eof_o
);
  logic cap_q, cap_d;

  always_comb cap_d = act_i ? act_start_i : cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
      sof_o <= 1'b0;
      eof_o <= 1'b0;
    end else begin
      cap_q <= cap_d;
      sof_o <= frame_evt_i & cap_d;
      eof_o <= frame_evt_i & cap_q;
    end
  end

  assign capture_o = cap_q;
endmodule

// File: rtl/vcap_run_seq.sv
module vcap_run_seq
  import vcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             progressive_i,
  input  logic             line_end_i,
  input  logic             vblank_i,
  input  logic             field_odd_i,
  output logic             capture_o,
  output logic             sof_o,
  output logic             eof_o
);
  logic line_evt, field_evt, frame_evt;
  logic act, act_start;

  vcap_timing u_timing (
    .clk(clk), .rst_n(rst_n), .progressive_i(progressive_i),
    .line_end_i(line_end_i), .vblank_i(vblank_i), .field_odd_i(field_odd_i),
    .line_evt_o(line_evt), .field_evt_o(field_evt), .frame_evt_o(frame_evt)
  );

  vcap_request u_req (
    .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr_i), .cmd_i(cmd_i),
    .line_evt_i(line_evt), .field_evt_i(field_evt), .frame_evt_i(frame_evt),
    .act_o(act), .act_start_o(act_start)
  );

  vcap_state u_state (
    .clk(clk), .rst_n(rst_n), .act_i(act), .act_start_i(act_start),
    .frame_evt_i(frame_evt), .capture_o(capture_o), .sof_o(sof_o), .eof_o(eof_o)
  );
endmodule

// File: rtl/vcap_run_seq_chk.sv
module vcap_run_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr_i,
  input logic [2:0] cmd_i,
  input logic       line_end_i,
  input logic       vblank_i,
  input logic       capture_o,
  input logic       sof_o,
  input logic       eof_o
);
  assert_start_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && cmd_i == 3'b111) |=> capture_o);

  assert_stop_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && cmd_i == 3'b000) |=> !capture_o);

  // R3 R4 R5: capture only begins after a write, a line pulse or a blanking edge
  assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_o) |-> ($past(cmd_wr_i) || $past(line_end_i) || $past(vblank_i)));

  assert_sof_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> capture_o);

  assert_eof_prior_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> $past(capture_o));

  assert_sof_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |=> !sof_o);

  assert_eof_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |=> !eof_o);
endmodule

bind vcap_run_seq vcap_run_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr_i), .cmd_i(cmd_i),
  .line_end_i(line_end_i), .vblank_i(vblank_i), .capture_o(capture_o),
  .sof_o(sof_o), .eof_o(eof_o)
);

// File: tb/vcap_run_seq_tb.sv
module vcap_run_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [2:0] cmd = 3'b000;
  logic progressive = 1'b0;
  logic line_end = 1'b0;
  logic vblank = 1'b0;
  logic field_odd = 1'b0;
  logic capture, sof, eof;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcap_run_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .cmd_i(cmd),
    .progressive_i(progressive), .line_end_i(line_end), .vblank_i(vblank),
    .field_odd_i(field_odd), .capture_o(capture), .sof_o(sof), .eof_o(eof)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] c);
    cmd_wr = 1'b1; cmd = c; tick(); cmd_wr = 1'b0;
  endtask

  task automatic line_pulse();
    line_end = 1'b1; tick(); line_end = 1'b0;
  endtask

  // Raise blanking with given parity; outputs are sampled one edge later by caller.
  task automatic vb_rise(logic odd);
    field_odd = odd; vblank = 1'b1; tick();
  endtask

  task automatic vb_fall();
    vblank = 1'b0; tick();
  endtask

  task automatic t_reset();
    check("R1", "capture after reset", capture, 1'b0);
    check("R1", "sof after reset", sof, 1'b0);
    check("R1", "eof after reset", eof, 1'b0);
    line_pulse(); vb_rise(1'b1);
    check("R1", "nothing pending", capture, 1'b0);
    vb_fall();
  endtask

  task automatic t_immediate();
    wr(3'b111);
    check("R2", "start now", capture, 1'b1);
    wr(3'b000);
    check("R2", "stop now", capture, 1'b0);
    wr(3'b100); wr(3'b111); wr(3'b000); line_pulse();
    check("R2", "immediate cancels pending", capture, 1'b0);
  endtask

  task automatic t_line();
    progressive = 1'b0;
    wr(3'b100);
    vb_rise(1'b1);
    check("R3", "blanking ignored by line start", capture, 1'b0);
    vb_fall(); tick();
    check("R3", "held before line end", capture, 1'b0);
    line_pulse();
    check("R3", "start at line", capture, 1'b1);
    wr(3'b001);
    vb_rise(1'b1);
    check("R3", "blanking ignored by line stop", capture, 1'b1);
    vb_fall();
    line_pulse();
    check("R3", "stop at line", capture, 1'b0);
  endtask

  task automatic t_field();
    progressive = 1'b0;
    wr(3'b101);
    line_pulse();
    check("R4", "line ignored by field start", capture, 1'b0);
    vb_rise(1'b0);
    check("R4", "start at field", capture, 1'b1);
    check("R5", "even-field edge gives no sof", sof, 1'b0);
    vb_fall();
    wr(3'b010); line_pulse();
    check("R4", "line ignored by field stop", capture, 1'b1);
    vb_rise(1'b0);
    check("R4", "stop at field", capture, 1'b0);
    vb_fall();
  endtask

  task automatic t_frame_interlaced();
    progressive = 1'b0;
    wr(3'b110);
    vb_rise(1'b0);
    check("R5", "even field is not a frame", capture, 1'b0);
    vb_fall();
    vb_rise(1'b1);
    check("R5", "start at odd-field end", capture, 1'b1);
    check("R8", "sof at start", sof, 1'b1);
    check("R8", "no eof at start", eof, 1'b0);
    vb_fall();
    check("R8", "sof one cycle", sof, 1'b0);
    wr(3'b011);
    vb_rise(1'b0);
    check("R5", "stop waits past even field", capture, 1'b1);
    vb_fall();
    vb_rise(1'b1);
    check("R5", "stop at odd-field end", capture, 1'b0);
    check("R8", "eof at stop", eof, 1'b1);
    check("R8", "no sof at stop", sof, 1'b0);
    vb_fall();
    check("R8", "eof one cycle", eof, 1'b0);
  endtask

  task automatic t_progressive();
    progressive = 1'b1;
    vb_rise(1'b1);
    check("R8", "no sof while idle", sof, 1'b0);
    check("R8", "no eof while idle", eof, 1'b0);
    vb_fall();
    wr(3'b110);
    vb_rise(1'b0);
    check("R6", "every field is a frame", capture, 1'b1);
    check("R6", "sof in progressive", sof, 1'b1);
    vb_fall();
    vb_rise(1'b0);
    check("R8", "sof while running", sof, 1'b1);
    check("R8", "eof while running", eof, 1'b1);
    vb_fall();
    wr(3'b000);
  endtask

  task automatic t_replace();
    progressive = 1'b0;
    wr(3'b100); wr(3'b110);
    line_pulse();
    check("R7", "replaced line start ignored", capture, 1'b0);
    wr(3'b101); wr(3'b100);
    vb_rise(1'b1);
    check("R7", "replaced field start ignored", capture, 1'b0);
    vb_fall();
    line_pulse();
    check("R7", "newer request served", capture, 1'b1);
    wr(3'b000);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_immediate();
    t_line();
    t_field();
    t_frame_interlaced();
    t_progressive();
    t_replace();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule